// File: doc/BRIEF.md
# Exception Request Priority Controller

This block sits beside the sequencer of a small CPU core. It collects the requests that can divert the core into exception handling and picks the single one to service. For each one it issues a start pulse together with a one-hot grant and a fixed vector number. The seven sources are, from most to least urgent:

1. core reset, including watchdog overflow
2. undefined opcode
3. trace
4. address error
5. interrupt
6. sleep instruction
7. trap instruction

Sources are not simply priority-encoded. Reset and undefined-opcode requests act in the cycle they arrive. Every other source is serviced only at an instruction boundary, which the sequencer signals when an instruction or an exception handling sequence completes. Context can also withhold a source:
- Trace is allowed only in interrupt control mode 2, and only with the trace enable set.
- Trace is never taken at a boundary that ends a return-from-exception.
- Interrupts are not seen at a boundary that ends a control-register logic or load instruction.
- Interrupts are not seen at the first boundary after reset handling.
- A sleep instruction counts as an exception only with standby-select clear and sleep-interrupt enable set.

Address-error, interrupt, sleep and trap requests are held in pending latches. Each latch is cleared only by its own grant or by reset. When several sources are eligible together, one is granted per boundary, in priority order.

Top module: `exc_arbiter`

## Requirements
- R1: While `core_rst_n_i` is low, `hold_o` reads 1 one cycle later and no start is issued. A rising edge of `core_rst_n_i` raises exactly one start in the next cycle, with grant bit 0 and vector 0. So does a `wdt_ovf_i` strobe while `core_rst_n_i` is high.
- R2: When reset holds or fires, every pending address-error, interrupt, sleep and trap request is discarded. None of them is granted at any later boundary.
- R3: An `illegal_i` strobe gives a start in the next cycle with grant bit 1 and vector 4, whether or not a boundary is present.
- R4: Trace (grant bit 2, vector 5) is granted at a boundary only when `icm_i` is 2, `trace_en_i` is 1 and `kind_i` is not 2'b10 (return-from-exception). It is never latched.
- R5: An address error (grant bit 3, vector 9) stays pending across non-boundary cycles. It is granted only at a boundary.
- R6: An interrupt (grant bit 4, vector 16) is granted at a boundary. It is not granted when `kind_i` is 2'b01 (control-register logic/load instruction), nor at the first boundary after a reset grant. It stays latched until a later boundary grants it.
- R7: `sleep_op_i` latches a sleep request (grant bit 5, vector 10) only when `ssby_i` is 0 and `slpie_i` is 1. Otherwise it has no effect.
- R8: When several sources are eligible in the same cycle, the lowest grant bit index wins and the rest stay pending. The order is reset(0), illegal(1), trace(2), address(3), interrupt(4), sleep(5), trap(6).
- R9: Each start lasts one cycle, with exactly one grant bit set and the source's fixed vector. With no start, the grant reads zero.
- R10: A `trap_i` strobe is latched at any time while the core is out of reset and is granted (grant bit 6, vector 8) at a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| core_rst_n_i | input | 1 | Core reset input; low holds the core, rising edge starts reset handling |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| illegal_i | input | 1 | Undefined opcode executed strobe |
| addr_err_i | input | 1 | Address error strobe |
| irq_i | input | 1 | Interrupt request strobe |
| sleep_op_i | input | 1 | Sleep instruction executed strobe |
| trap_i | input | 1 | Trap instruction strobe |
| boundary_i | input | 1 | Instruction or exception handling completed this cycle |
| kind_i | input | 2 | Kind of the completing instruction: 01 control logic/load, 10 return-from-exception, others plain |
| icm_i | input | 2 | Interrupt control mode |
| trace_en_i | input | 1 | Trace enable bit |
| ssby_i | input | 1 | Standby-select configuration bit |
| slpie_i | input | 1 | Sleep-interrupt enable configuration bit |
| start_o | output | 1 | One-cycle start of exception handling |
| grant_o | output | 7 | One-hot grant, bit index as in R8 |
| vec_o | output | 8 | Vector number of the granted source |
| hold_o | output | 1 | Core held in reset state |

## Verification
The checker relies on a few assumptions about the inputs:
- `kind_i` and `icm_i` are valid in the cycle where `boundary_i` is high.
- Request strobes last one cycle.
- The sequencer pulses `boundary_i` only when an instruction or a handling sequence really completes.

The bench keeps to these assumptions. It changes every input only on the falling clock edge and drops all strobes after one cycle. It also keeps mode and configuration bits steady across each boundary it drives. Its sweep posts every combination of the five boundary-serviced sources and then steps boundaries one at a time. At each boundary it computes the expected winner as the lowest set bit of what remains.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NSRC = 7;
    localparam int VW   = 8;

    localparam int B_RST = 0;
    localparam int B_ILL = 1;
    localparam int B_TRC = 2;
    localparam int B_ADR = 3;
    localparam int B_IRQ = 4;
    localparam int B_SLP = 5;
    localparam int B_TRP = 6;

    localparam logic [1:0] KIND_CTRL  = 2'b01;
    localparam logic [1:0] KIND_RTE   = 2'b10;
    localparam logic [1:0] MODE_TRACE = 2'd2;

    function automatic logic [VW-1:0] vec_of(input logic [NSRC-1:0] oh);
        logic [VW-1:0] v;
        v = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (oh[i]) begin
                case (i)
                    B_RST:   v = v | VW'(0);
                    B_ILL:   v = v | VW'(4);
                    B_TRC:   v = v | VW'(5);
                    B_ADR:   v = v | VW'(9);
                    B_IRQ:   v = v | VW'(16);
                    B_SLP:   v = v | VW'(10);
                    default: v = v | VW'(8);
                endcase
            end
        end
        return v;
    endfunction

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            pin;
        logic            after_rst;
        logic            hold;
        logic            start;
        logic [NSRC-1:0] grant;
        logic [VW-1:0]   vec;
    } arb_state_t;
endpackage

// File: rtl/exc_capture.sv
module exc_capture
    import exc_pkg::*;
(
    input  logic [NSRC-1:0] pend_q,
    input  logic            addr_err_i,
    input  logic            irq_i,
    input  logic            sleep_op_i,
    input  logic            trap_i,
    input  logic            ssby_i,
    input  logic            slpie_i,
    output logic [NSRC-1:0] merged
);
    logic [NSRC-1:0] fresh;

    always_comb begin
        fresh        = '0;
        fresh[B_ADR] = addr_err_i;
        fresh[B_IRQ] = irq_i;
        fresh[B_SLP] = sleep_op_i && !ssby_i && slpie_i;
        fresh[B_TRP] = trap_i;
        merged       = pend_q | fresh;
    end
endmodule

// File: rtl/exc_gate.sv
module exc_gate
    import exc_pkg::*;
(
    input  logic [NSRC-1:0] merged,
    input  logic            live,
    input  logic            rst_evt,
    input  logic            illegal_i,
    input  logic            boundary_i,
    input  logic [1:0]      kind_i,
    input  logic [1:0]      icm_i,
    input  logic            trace_en_i,
    input  logic            after_rst,
    output logic [NSRC-1:0] cand
);
    logic bnd;

    always_comb begin
        bnd         = live && boundary_i;
        cand        = '0;
        cand[B_RST] = rst_evt;
        cand[B_ILL] = live && illegal_i;
        cand[B_TRC] = bnd && trace_en_i && (icm_i == MODE_TRACE) && (kind_i != KIND_RTE);
        cand[B_ADR] = bnd && merged[B_ADR];
        cand[B_IRQ] = bnd && merged[B_IRQ] && (kind_i != KIND_CTRL) && !after_rst;
        cand[B_SLP] = bnd && merged[B_SLP];
        cand[B_TRP] = bnd && merged[B_TRP];
    end
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign oh[g]      = req[g] && !taken[g];
        assign taken[g+1] = taken[g] || req[g];
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic            core_rst_n_i,
    input  logic            wdt_ovf_i,
    input  logic            illegal_i,
    input  logic            addr_err_i,
    input  logic            irq_i,
    input  logic            sleep_op_i,
    input  logic            trap_i,
    input  logic            boundary_i,
    input  logic [1:0]      kind_i,
    input  logic [1:0]      icm_i,
    input  logic            trace_en_i,
    input  logic            ssby_i,
    input  logic            slpie_i,
    output logic            start_o,
    output logic [NSRC-1:0] grant_o,
    output logic [VW-1:0]   vec_o,
    output logic            hold_o
);
    arb_state_t      st_d, st_q;
    logic [NSRC-1:0] merged;
    logic [NSRC-1:0] cand;
    logic [NSRC-1:0] pick_oh;
    logic            rst_evt;

    assign rst_evt = core_rst_n_i && (!st_q.pin || wdt_ovf_i);

    exc_capture cap_i (
        .pend_q     (st_q.pend),
        .addr_err_i (addr_err_i),
        .irq_i      (irq_i),
        .sleep_op_i (sleep_op_i),
        .trap_i     (trap_i),
        .ssby_i     (ssby_i),
        .slpie_i    (slpie_i),
        .merged     (merged)
    );

    exc_gate gate_i (
        .merged     (merged),
        .live       (core_rst_n_i),
        .rst_evt    (rst_evt),
        .illegal_i  (illegal_i),
        .boundary_i (boundary_i),
        .kind_i     (kind_i),
        .icm_i      (icm_i),
        .trace_en_i (trace_en_i),
        .after_rst  (st_q.after_rst),
        .cand       (cand)
    );

    exc_pick #(.N(NSRC)) pick_i (
        .req (cand),
        .oh  (pick_oh)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pin   = core_rst_n_i;
        st_d.hold  = !core_rst_n_i;
        st_d.start = |pick_oh;
        st_d.grant = pick_oh;
        st_d.vec   = vec_of(pick_oh);
        if (!core_rst_n_i || rst_evt) begin
            st_d.pend = '0;
        end else begin
            st_d.pend = merged & ~pick_oh;
        end
        if (!core_rst_n_i) begin
            st_d.after_rst = 1'b0;
        end else if (rst_evt) begin
            st_d.after_rst = 1'b1;
        end else if (boundary_i) begin
            st_d.after_rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q           <= '0;
            st_q.hold      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;
    assign grant_o = st_q.grant;
    assign vec_o   = st_q.vec;
    assign hold_o  = st_q.hold;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk (
    input logic       clk,
    input logic       por_n,
    input logic       core_rst_n_i,
    input logic       boundary_i,
    input logic [1:0] kind_i,
    input logic [1:0] icm_i,
    input logic       trace_en_i,
    input logic       start_o,
    input logic [6:0] grant_o,
    input logic [7:0] vec_o,
    input logic       hold_o
);
    AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n_i |=> hold_o); // R1
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!por_n)
        hold_o |-> !start_o); // R1
    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!por_n)
        (start_o && grant_o[0]) |-> (vec_o == 8'd0)); // R1
    AST_TRACE_GATED: assert property (@(posedge clk) disable iff (!por_n)
        (start_o && grant_o[2]) |-> ($past(icm_i) == 2'd2 && $past(trace_en_i) && $past(kind_i) != 2'b10)); // R4
    AST_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!por_n)
        (start_o && (grant_o[6:2] != 5'd0)) |-> $past(boundary_i)); // R5
    AST_IRQ_NOT_CTRL: assert property (@(posedge clk) disable iff (!por_n)
        (start_o && grant_o[4]) |-> ($past(kind_i) != 2'b01)); // R6
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
        start_o |-> $onehot(grant_o)); // R9
    AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        !start_o |-> (grant_o == 7'd0)); // R9
endmodule

bind exc_arbiter exc_arbiter_chk chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .core_rst_n_i (core_rst_n_i),
    .boundary_i   (boundary_i),
    .kind_i       (kind_i),
    .icm_i        (icm_i),
    .trace_en_i   (trace_en_i),
    .start_o      (start_o),
    .grant_o      (grant_o),
    .vec_o        (vec_o),
    .hold_o       (hold_o)
);

// File: tb/exc_arbiter_tb_top.sv
`timescale 1ns/100ps
module exc_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       core_rst_n = 1'b0;
    logic       wdt = 1'b0, ill = 1'b0, adr = 1'b0, irq = 1'b0, slp = 1'b0, trp = 1'b0;
    logic       bnd = 1'b0;
    logic [1:0] kind = 2'b00;
    logic [1:0] icm = 2'd2;
    logic       tren = 1'b0, ssby = 1'b0, slpie = 1'b1;
    logic       start;
    logic [6:0] grant;
    logic [7:0] vec;
    logic       hold;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    exc_arbiter dut_i (
        .clk(clk), .por_n(por_n), .core_rst_n_i(core_rst_n), .wdt_ovf_i(wdt),
        .illegal_i(ill), .addr_err_i(adr), .irq_i(irq), .sleep_op_i(slp), .trap_i(trp),
        .boundary_i(bnd), .kind_i(kind), .icm_i(icm), .trace_en_i(tren),
        .ssby_i(ssby), .slpie_i(slpie),
        .start_o(start), .grant_o(grant), .vec_o(vec), .hold_o(hold)
    );

    function automatic logic [7:0] exp_vec(input logic [6:0] oh);
        case (oh)
            7'b0000001: return 8'd0;
            7'b0000010: return 8'd4;
            7'b0000100: return 8'd5;
            7'b0001000: return 8'd9;
            7'b0010000: return 8'd16;
            7'b0100000: return 8'd10;
            7'b1000000: return 8'd8;
            default:    return 8'd0;
        endcase
    endfunction

    // Inputs set now take effect at the next rising edge; outputs are read at the following falling edge.
    task automatic step(input logic [6:0] exp_oh, input string tag);
        logic exp_start;
        @(negedge clk);
        exp_start = (exp_oh != 7'd0);
        n_chk++;
        if (start !== exp_start || grant !== exp_oh || (exp_start && vec !== exp_vec(exp_oh))) begin
            n_bad++;
            $display("FAIL %s: start=%0b grant=%b vec=%0d expected start=%0b grant=%b vec=%0d",
                     tag, start, grant, vec, exp_start, exp_oh, exp_vec(exp_oh));
        end
        wdt = 0; ill = 0; adr = 0; irq = 0; slp = 0; trp = 0; bnd = 0; kind = 2'b00;
    endtask

    task automatic check_hold(input logic e, input string tag);
        n_chk++;
        if (hold !== e) begin
            n_bad++;
            $display("FAIL %s: hold=%0b expected %0b", tag, hold, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state: core held, nothing started
        check_hold(1'b1, "R1 hold at reset");
        // R1/R2: requests while core reset is low are dropped
        trp = 1; bnd = 1; irq = 1;
        step(7'd0, "R1 no start while held");
        check_hold(1'b1, "R1 hold while low");
        core_rst_n = 1'b1;
        step(7'b0000001, "R1 rising edge reset grant");
        check_hold(1'b0, "R1 hold released");
        bnd = 1;
        step(7'd0, "R2 held trap discarded");
        // R6: interrupt inhibited at first boundary after reset, then granted
        wdt = 1;
        step(7'b0000001, "R1 watchdog reset");
        irq = 1;
        step(7'd0, "R6 irq latched no boundary");
        bnd = 1;
        step(7'd0, "R6 irq inhibited after reset");
        bnd = 1;
        step(7'b0010000, "R6 irq granted later");
        // R2: pending trap killed by watchdog reset
        trp = 1;
        step(7'd0, "R10 trap waits for boundary");
        wdt = 1;
        step(7'b0000001, "R2 watchdog with trap pending");
        bnd = 1;
        step(7'd0, "R2 trap discarded b1");
        bnd = 1;
        step(7'd0, "R2 trap discarded b2");
        // R3: illegal immediate
        ill = 1;
        step(7'b0000010, "R3 illegal immediate");
        // R6: control-register instruction inhibits interrupt
        irq = 1; bnd = 1; kind = 2'b01;
        step(7'd0, "R6 irq inhibited after ctrl instr");
        bnd = 1;
        step(7'b0010000, "R6 irq granted at plain boundary");
        // R4: trace only in mode 2, not after return-from-exception
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                icm = 2'(m); tren = 1; kind = 2'(k); bnd = 1;
                step((m == 2 && k != 2) ? 7'b0000100 : 7'd0, "R4 trace gating");
            end
        end
        icm = 2'd0; tren = 1; bnd = 1;
        step(7'd0, "R4 trace enabled wrong mode");
        icm = 2'd2; tren = 0;
        // R7: sleep configuration gating
        for (int c = 0; c < 4; c++) begin
            ssby = c[1]; slpie = c[0];
            slp = 1;
            step(7'd0, "R7 sleep latched no boundary");
            bnd = 1;
            step((c == 1) ? 7'b0100000 : 7'd0, "R7 sleep config gating");
        end
        ssby = 0; slpie = 1;
        // R8: illegal beats boundary sources, address error survives
        adr = 1;
        step(7'd0, "R5 address error held");
        step(7'd0, "R5 address error still held");
        ill = 1; bnd = 1;
        step(7'b0000010, "R8 illegal over address error");
        bnd = 1;
        step(7'b0001000, "R5 address error at boundary");
        // R8: reset beats illegal
        wdt = 1; ill = 1;
        step(7'b0000001, "R8 reset over illegal");
        bnd = 1;
        step(7'd0, "R8 empty after reset");
        // R8/R9/R10 sweep over all boundary-source combinations
        for (int m = 0; m < 32; m++) begin
            logic [6:0] rem;
            rem = {2'b00, 5'(m)} << 2;
            adr = m[1]; irq = m[2]; slp = m[3]; trp = m[4];
            step(7'd0, "R5 sweep nothing before boundary");
            tren = m[0]; icm = 2'd2; bnd = 1;
            while (rem != 7'd0) begin
                logic [6:0] low;
                low = rem & (~rem + 7'd1);
                step(low, "R8 sweep priority order");
                rem = rem & ~low;
                tren = 0; bnd = 1;
            end
            tren = 0;
            step(7'd0, "R9 sweep drained");
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule